// File: doc/BRIEF.md
# Snoopy Key Ownership Controller

This block gives each of several compute units exclusive ownership of keys in a shared key-value table before the unit touches them. Each unit has its own controller with a small set of keys it currently owns. A unit asks for a key through a valid/ready request channel. Its controller then competes for a shared snoop bus. A round-robin arbiter gives that bus to one controller per cycle. The winning controller broadcasts its key, and every other controller compares it against the keys it owns. Any match raises a shared busy line.

If no other unit owns the key, the requesting controller adds it to its owned set and pulses a grant to its unit. On a busy answer, the controller gives up the bus and competes again on later cycles until the key is free. A unit hands a key back with a release strobe, and the key leaves its owned set at the next clock edge. The arbiter handles one broadcast per cycle, and ownership is recorded at the end of that cycle. Two units asking for the same key in the same cycle are therefore served one after the other, and only the first one succeeds.

Back-pressure on the request channel works like this. A unit holds `req_valid` and its key steady until it sees `req_ready`. `req_ready` is low while that unit's controller is still working on an earlier request, and also while the unit's owned set is full. Release and grant are plain one-cycle strobes.

Top module: `key_own_ctrl`

## Requirements
- R1: After reset every `req_ready` bit is 1, every `grant` bit is 0 and no unit owns a key.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` of that unit are both 1. If the unit wins the bus in the next cycle and no other unit owns the key, `grant` for that unit is 1 for exactly one cycle, two cycles after the accepting edge.
- R3: A request for a key owned by another unit is never granted while that key stays owned. The requester keeps retrying, and its `req_ready` stays 0.
- R4: A release strobe removes the key from the unit's owned set at the next clock edge. A snoop in the same cycle as the release still sees the key as owned, so a waiting requester that is alone on the bus is granted two cycles after the release cycle.
- R5: When two units request the same free key in the same cycle, exactly one of them is granted. The other keeps waiting until that key is released.
- R6: The snoop bus is granted to at most one requesting controller per cycle, in round-robin order. Unit 0 has first priority after reset, and after each grant the search starts at the unit above the last winner.
- R7: When a unit owns OWN_DEPTH keys, its `req_ready` is 0. A release makes it 1 again from the next cycle.
- R8: At most one `grant` bit is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_UNITS | Per-unit ownership request valid |
| req_ready | output | N_UNITS | Per-unit request ready |
| req_key | input | N_UNITS*KEY_W | Per-unit requested key, unit u in bits [u*KEY_W +: KEY_W] |
| rel_valid | input | N_UNITS | Per-unit release strobe |
| rel_key | input | N_UNITS*KEY_W | Per-unit key to release, same slicing as req_key |
| grant | output | N_UNITS | Per-unit one-cycle ownership grant |

## Verification
Four units asking for four distinct keys in the same cycle show the round-robin order and the one-per-cycle serialization through the exact grant cycles. A request for a key that another unit owns, followed by a release, separates correct exclusion from a missing snoop. The grant cycle after the release also tells a release taking effect at the next edge apart from one taking effect in the same cycle. Two units asking for one key at once show that only the arbitration winner gets it. Filling one unit's owned set and then releasing a key shows the back-pressure of `req_ready` appearing and clearing.

// File: rtl/key_own_pkg.sv
package key_own_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ARB  = 1'b1
  } own_state_e;
endpackage

// File: rtl/key_own_arb.sv
module key_own_arb #(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] req,
  output logic [N_UNITS-1:0] gnt
);
  localparam int UW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic [UW-1:0] last_q;
  logic [UW-1:0] win;
  logic          found;

  always_comb begin
    int idx;
    gnt   = '0;
    found = 1'b0;
    win   = last_q;
    for (int o = 1; o <= N_UNITS; o++) begin
      idx = (int'(last_q) + o) % N_UNITS;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        win      = UW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= UW'(N_UNITS - 1);
    else if (found) last_q <= win;
  end

  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r6_only_requesters: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  a_r6_no_idle_bus: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|gnt));
endmodule

// File: rtl/key_own_hold_set.sv
module key_own_hold_set #(
  parameter int KEY_W     = 8,
  parameter int OWN_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [KEY_W-1:0] ins_key,
  input  logic             rel_en,
  input  logic [KEY_W-1:0] rel_key,
  input  logic [KEY_W-1:0] probe_key,
  output logic             probe_hit,
  output logic             has_free
);
  logic [OWN_DEPTH-1:0] vld_q;
  logic [KEY_W-1:0]     key_q [OWN_DEPTH];
  logic [OWN_DEPTH-1:0] slot_sel;
  logic [OWN_DEPTH-1:0] hit_vec;

  always_comb begin
    slot_sel = '0;
    for (int s = 0; s < OWN_DEPTH; s++)
      if (!vld_q[s] && slot_sel == '0) slot_sel[s] = 1'b1;
  end

  assign has_free  = ~&vld_q;
  assign probe_hit = |hit_vec;

  for (genvar s = 0; s < OWN_DEPTH; s++) begin : g_slot
    assign hit_vec[s] = vld_q[s] && (key_q[s] == probe_key);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        key_q[s] <= '0;
      end else if (ins_en && slot_sel[s]) begin
        vld_q[s] <= 1'b1;
        key_q[s] <= ins_key;
      end else if (rel_en && vld_q[s] && key_q[s] == rel_key) begin
        vld_q[s] <= 1'b0;
      end
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) ins_en |-> has_free);
endmodule

// File: rtl/key_own_unit.sv
module key_own_unit
  import key_own_pkg::*;
#(
  parameter int KEY_W     = 8,
  parameter int OWN_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [KEY_W-1:0] req_key,
  input  logic             rel_valid,
  input  logic [KEY_W-1:0] rel_key,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [KEY_W-1:0] my_key,
  input  logic [KEY_W-1:0] snoop_key,
  input  logic             busy_in,
  output logic             snoop_hit,
  output logic             grant
);
  own_state_e       state_q;
  logic [KEY_W-1:0] key_q;
  logic             has_free;
  logic             accept;
  logic             win;
  logic             grant_q;

  assign req_ready = (state_q == ST_IDLE) && has_free;
  assign accept    = req_valid && req_ready;
  assign bus_req   = (state_q == ST_ARB);
  assign win       = bus_req && bus_gnt && !busy_in;
  assign my_key    = key_q;
  assign grant     = grant_q;

  key_own_hold_set #(.KEY_W(KEY_W), .OWN_DEPTH(OWN_DEPTH)) u_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (win),
    .ins_key  (key_q),
    .rel_en   (rel_valid),
    .rel_key  (rel_key),
    .probe_key(snoop_key),
    .probe_hit(snoop_hit),
    .has_free (has_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= win;
      if (accept) begin
        state_q <= ST_ARB;
        key_q   <= req_key;
      end else if (win) begin
        state_q <= ST_IDLE;
      end
    end
  end

  a_r2_accept_competes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_req);
  a_r3_grant_needs_clear_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(bus_gnt && !busy_in));
  a_r2_grant_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
endmodule

// File: rtl/key_own_ctrl.sv
module key_own_ctrl #(
  parameter int N_UNITS   = 4,
  parameter int KEY_W     = 8,
  parameter int OWN_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_UNITS-1:0]         req_valid,
  output logic [N_UNITS-1:0]         req_ready,
  input  logic [N_UNITS*KEY_W-1:0]   req_key,
  input  logic [N_UNITS-1:0]         rel_valid,
  input  logic [N_UNITS*KEY_W-1:0]   rel_key,
  output logic [N_UNITS-1:0]         grant
);
  logic [N_UNITS-1:0] bus_req;
  logic [N_UNITS-1:0] bus_gnt;
  logic [N_UNITS-1:0] hit;
  logic [KEY_W-1:0]   unit_key [N_UNITS];
  logic [KEY_W-1:0]   bus_key;
  logic               busy;

  key_own_arb #(.N_UNITS(N_UNITS)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (bus_req),
    .gnt  (bus_gnt)
  );

  always_comb begin
    bus_key = '0;
    for (int u = 0; u < N_UNITS; u++)
      if (bus_gnt[u]) bus_key = bus_key | unit_key[u];
  end

  assign busy = |(hit & ~bus_gnt);

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    key_own_unit #(.KEY_W(KEY_W), .OWN_DEPTH(OWN_DEPTH)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid[u]),
      .req_ready(req_ready[u]),
      .req_key  (req_key[u*KEY_W +: KEY_W]),
      .rel_valid(rel_valid[u]),
      .rel_key  (rel_key[u*KEY_W +: KEY_W]),
      .bus_req  (bus_req[u]),
      .bus_gnt  (bus_gnt[u]),
      .my_key   (unit_key[u]),
      .snoop_key(bus_key),
      .busy_in  (busy),
      .snoop_hit(hit[u]),
      .grant    (grant[u])
    );
  end

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
endmodule

// File: tb/key_own_ctrl_test.sv
module key_own_ctrl_test;
  localparam int N  = 4;
  localparam int KW = 8;
  localparam int D  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N*KW-1:0] req_key = '0;
  logic [N-1:0]    rel_valid = '0;
  logic [N*KW-1:0] rel_key = '0;
  logic [N-1:0]    grant;

  int cyc = 0;
  int gcnt [N];
  int gcyc [N];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  key_own_ctrl #(.N_UNITS(N), .KEY_W(KW), .OWN_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_key(req_key), .rel_valid(rel_valid), .rel_key(rel_key), .grant(grant)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial for (int u = 0; u < N; u++) begin gcnt[u] = 0; gcyc[u] = -1; end

  always @(negedge clk)
    if (rst_n)
      for (int u = 0; u < N; u++)
        if (grant[u]) begin gcnt[u] = gcnt[u] + 1; gcyc[u] = cyc; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic set_req(input int u, input int key);
    req_valid[u] = 1'b1;
    req_key[u*KW +: KW] = KW'(key);
  endtask

  task automatic pulse_rel(input int u, input int key, output int when);
    rel_valid[u] = 1'b1;
    rel_key[u*KW +: KW] = KW'(key);
    when = cyc;
    step();
    rel_valid[u] = 1'b0;
  endtask

  task automatic t_reset;
    check(req_ready == '1, "R1 ready after reset", int'(req_ready), (1 << N) - 1);
    check(grant == '0, "R1 grant after reset", int'(grant), 0);
  endtask

  task automatic t_distinct;
    int k;
    k = cyc;
    for (int u = 0; u < N; u++) set_req(u, u + 1);
    step();
    req_valid = '0;
    step(6);
    for (int u = 0; u < N; u++) begin
      check(gcnt[u] == 1, "R2 one grant per distinct key", gcnt[u], 1);
      check(gcyc[u] == k + 2 + u, "R6 round-robin grant cycle", gcyc[u], k + 2 + u);
    end
  endtask

  task automatic t_conflict;
    int j;
    set_req(1, 1);
    step();
    req_valid[1] = 1'b0;
    step(8);
    check(gcnt[1] == 1, "R3 no grant for owned key", gcnt[1], 1);
    check(req_ready[1] == 1'b0, "R3 ready low while retrying", int'(req_ready[1]), 0);
    pulse_rel(0, 1, j);
    step(3);
    check(gcnt[1] == 2, "R4 grant after release", gcnt[1], 2);
    check(gcyc[1] == j + 2, "R4 release seen next cycle", gcyc[1], j + 2);
  endtask

  task automatic t_same_key;
    int k, j;
    k = cyc;
    set_req(2, 9);
    set_req(3, 9);
    step();
    req_valid = '0;
    step(6);
    check(gcnt[2] == 2, "R5 first contender granted", gcnt[2], 2);
    check(gcyc[2] == k + 2, "R5 winner grant cycle", gcyc[2], k + 2);
    check(gcnt[3] == 1, "R5 second contender waits", gcnt[3], 1);
    check(req_ready[3] == 1'b0, "R5 loser still busy", int'(req_ready[3]), 0);
    pulse_rel(2, 9, j);
    step(3);
    check(gcnt[3] == 2, "R5 loser granted after release", gcnt[3], 2);
    check(gcyc[3] == j + 2, "R5 loser grant cycle", gcyc[3], j + 2);
  endtask

  task automatic t_capacity;
    int j, base;
    for (int i = 0; i < D; i++) begin
      set_req(0, 20 + i);
      step();
      req_valid[0] = 1'b0;
      step(3);
    end
    check(gcnt[0] == 1 + D, "R7 all slots granted", gcnt[0], 1 + D);
    check(req_ready[0] == 1'b0, "R7 ready low when full", int'(req_ready[0]), 0);
    base = gcnt[0];
    set_req(0, 30);
    step(3);
    check(gcnt[0] == base, "R7 full set blocks request", gcnt[0], base);
    pulse_rel(0, 20, j);
    check(req_ready[0] == 1'b1, "R7 ready back after release", int'(req_ready[0]), 1);
    step();
    req_valid[0] = 1'b0;
    step(3);
    check(gcnt[0] == base + 1, "R7 request accepted after release", gcnt[0], base + 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_distinct();
    t_conflict();
    t_same_key();
    t_capacity();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule